// File: doc/BRIEF.md
# Fractional Pulse-Swallow Divider Controller

This block holds the digital counters of a feedback divider that sits behind an external dual-modulus prescaler. It is clocked by the prescaler output. It drives a modulus-control line that asks the prescaler to divide by P+1 or by P, and it raises one output pulse per division cycle. The prescaler base P is picked by a select input: 32 for the high-band loop and 16 for the low-band loop. A division cycle lasts M prescaler periods. In the first S of them the prescaler runs at P+1 and in the rest at P, so one cycle spans P*M + S input (VCO) periods.

S is the swallow count A, or A+1 when a 5-bit fraction accumulator overflows. At each cycle boundary the accumulator adds the numerator F modulo 32. Over any 32 consecutive cycles it produces exactly F carries, so the average ratio is P*M + A + F/32. An even F gives a shorter repeat pattern: F=12 repeats every 8 cycles with 3 carries. M, A, F and the P select are sampled only at a cycle boundary. A configuration flag reports settings that give no continuous channel coverage.

The sequencer is a three-state machine:
- IDLE is entered from reset. Its only transition is the first load, to SWALLOW, or to FILL when S is 0.
- SWALLOW drives modulus control high. It moves to FILL once S periods have passed. At the end of the cycle it reloads into SWALLOW or FILL.
- FILL drives modulus control low. It stays in FILL until the end of the cycle, then reloads into SWALLOW or FILL.

Top module: `pswallow_frac_div`

## Requirements
- R1: Each division cycle lasts max(M,1) prescaler periods. `div_pulse` is high only in the last period of the cycle.
- R2: Within a cycle `mod_ctl` is high for a contiguous run of periods that starts with the cycle's first period, and low afterwards.
- R3: The run length S is A, or A+1 when the 5-bit accumulator (acc + F) overflows at the boundary that starts the cycle. Over 32 cycles after reset the total input count is exactly 32*(P*M + A) + F, and F=12 yields 3 carries in the first 8 cycles.
- R4: M, A, F and `p32_sel` are captured only at the boundary that starts a cycle. Changes made in the middle of a cycle leave the current cycle's length unchanged.
- R5: `p32_act` is 1 while the captured base P is 32 and 0 while it is 16. It is updated only at a boundary.
- R6: `cfg_err` is 1 for a captured configuration with A > M, or with P*M + A below 1024 (P=32) or below 256 (P=16). Otherwise it is 0. It is updated at a boundary.
- R7: During reset `mod_ctl`, `div_pulse`, `cfg_err` and `p32_act` are 0 and the accumulator is cleared. The first boundary is the first clock edge after reset is released.
- R8: When S reaches or exceeds M (A = M, possibly with a carry), `mod_ctl` stays high for the whole cycle and the extra carry count is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_val | input | 11 | Main count M |
| a_val | input | 5 | Swallow count A |
| f_val | input | 5 | Fraction numerator F (denominator 32) |
| p32_sel | input | 1 | 1 selects P=32, 0 selects P=16 |
| mod_ctl | output | 1 | 1 requests divide by P+1, 0 requests P |
| div_pulse | output | 1 | High during the last period of each cycle |
| p32_act | output | 1 | Captured P select |
| cfg_err | output | 1 | Captured configuration is invalid |

## Verification
The bench models the prescaler by adding P or P+1 for each sampled period, and compares the total over 32 cycles with the formula. A design that dropped or doubled carries would be off by F or more. A design that mixed up the order of swallow and fill would fail the contiguity check. The corner cases are:
- A = 0, where a design that stays one period in the swallow state would add 1 per cycle.
- A = 31 with F = 31.
- A = M, where a design that extends the cycle for the lost carry would lengthen it.
- The exact minimum ratios of 1024 and 256, which a design using a strict comparison would flag wrongly.

A configuration change in the middle of a cycle must not alter the current cycle's length or the captured P. A design that captured inputs every clock would end that cycle early.

// File: rtl/divc_pkg.sv
package divc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_FILL    = 2'd2
    } div_state_e;

endpackage

// File: rtl/divc_frac_acc.sv
module divc_frac_acc #(
    parameter int F_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [F_W-1:0] f_in,
    output logic           carry
);
    logic [F_W-1:0] acc_q;
    logic [F_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, f_in};
        carry = sum[F_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= sum[F_W-1:0];
        end
    end
endmodule

// File: rtl/divc_cfg_check.sv
module divc_cfg_check #(
    parameter int M_W    = 11,
    parameter int A_W    = 5,
    parameter int P_HI   = 32,
    parameter int P_LO   = 16,
    parameter int MIN_HI = 1024,
    parameter int MIN_LO = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic           p_hi_in,
    output logic           err_q,
    output logic           p_hi_q
);
    localparam int R_W = M_W + $clog2(P_HI) + 2;

    logic [R_W-1:0] ratio;
    logic [R_W-1:0] min_ratio;
    logic           bad;

    always_comb begin
        ratio     = (p_hi_in ? R_W'(m_in) * R_W'(P_HI) : R_W'(m_in) * R_W'(P_LO)) + R_W'(a_in);
        min_ratio = p_hi_in ? R_W'(MIN_HI) : R_W'(MIN_LO);
        bad       = (M_W'(a_in) > m_in) || (ratio < min_ratio);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            p_hi_q <= 1'b0;
        end else if (load) begin
            err_q  <= bad;
            p_hi_q <= p_hi_in;
        end
    end
endmodule

// File: rtl/divc_seq.sv
module divc_seq
    import divc_pkg::*;
#(
    parameter int M_W = 11,
    parameter int A_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic           carry,
    output logic           load,
    output div_state_e     state,
    output logic           mod_ctl,
    output logic           div_pulse,
    output logic [M_W-1:0] m_act,
    output logic [A_W-1:0] a_act
);
    localparam int S_W = A_W + 1;

    div_state_e     state_q, state_d, load_target;
    logic [M_W-1:0] cnt_q;
    logic [M_W:0]   cnt_nx;
    logic [S_W-1:0] swal_q, swal_nx;
    logic           end_cyc;

    always_comb begin
        cnt_nx      = {1'b0, cnt_q} + 1'b1;
        end_cyc     = (state_q != ST_IDLE) && (cnt_nx >= {1'b0, m_act});
        load        = (state_q == ST_IDLE) || end_cyc;
        swal_nx     = {1'b0, a_in} + S_W'(carry);
        load_target = (swal_nx != '0) ? ST_SWALLOW : ST_FILL;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = load_target;
            ST_SWALLOW: begin
                if (end_cyc)
                    state_d = load_target;
                else if (cnt_nx >= (M_W+1)'(swal_q))
                    state_d = ST_FILL;
            end
            ST_FILL:    if (end_cyc) state_d = load_target;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            swal_q <= '0;
            m_act  <= '0;
            a_act  <= '0;
        end else if (load) begin
            cnt_q  <= '0;
            swal_q <= swal_nx;
            m_act  <= m_in;
            a_act  <= a_in;
        end else begin
            cnt_q  <= cnt_nx[M_W-1:0];
        end
    end

    // outputs
    always_comb begin
        state     = state_q;
        mod_ctl   = (state_q == ST_SWALLOW);
        div_pulse = end_cyc;
    end
endmodule

// File: rtl/pswallow_frac_div.sv
module pswallow_frac_div
    import divc_pkg::*;
#(
    parameter int M_W    = 11,
    parameter int A_W    = 5,
    parameter int F_W    = 5,
    parameter int P_HI   = 32,
    parameter int P_LO   = 16,
    parameter int MIN_HI = 1024,
    parameter int MIN_LO = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic [F_W-1:0] f_val,
    input  logic           p32_sel,
    output logic           mod_ctl,
    output logic           div_pulse,
    output logic           p32_act,
    output logic           cfg_err
);
    logic           load_w;
    logic           carry_w;
    div_state_e     st_w;
    logic [M_W-1:0] m_act_w;
    logic [A_W-1:0] a_act_w;

    divc_frac_acc #(.F_W(F_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .f_in  (f_val),
        .carry (carry_w)
    );

    divc_seq #(.M_W(M_W), .A_W(A_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_in      (m_val),
        .a_in      (a_val),
        .carry     (carry_w),
        .load      (load_w),
        .state     (st_w),
        .mod_ctl   (mod_ctl),
        .div_pulse (div_pulse),
        .m_act     (m_act_w),
        .a_act     (a_act_w)
    );

    divc_cfg_check #(
        .M_W(M_W), .A_W(A_W), .P_HI(P_HI), .P_LO(P_LO),
        .MIN_HI(MIN_HI), .MIN_LO(MIN_LO)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .m_in    (m_val),
        .a_in    (a_val),
        .p_hi_in (p32_sel),
        .err_q   (cfg_err),
        .p_hi_q  (p32_act)
    );
endmodule

// File: rtl/pswallow_frac_div_chk.sv
module pswallow_frac_div_chk
    import divc_pkg::*;
#(
    parameter int M_W = 11,
    parameter int A_W = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           load,
    input div_state_e     state,
    input logic           mod_ctl,
    input logic           div_pulse,
    input logic [M_W-1:0] m_act,
    input logic [A_W-1:0] a_act,
    input logic           p32_act,
    input logic           cfg_err
);
    logic [M_W:0] per_cnt;
    logic [M_W:0] hi_cnt;
    logic [M_W:0] hi_tot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt <= '0;
            hi_cnt  <= '0;
        end else if (load) begin
            per_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            per_cnt <= per_cnt + 1'b1;
            hi_cnt  <= hi_cnt + (M_W+1)'(mod_ctl);
        end
    end

    assign hi_tot = hi_cnt + (M_W+1)'(mod_ctl);

    a_r1_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && m_act != '0) |-> (per_cnt == {1'b0, m_act} - 1'b1));

    a_r2_swallow_front: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !mod_ctl && !div_pulse) |=> !mod_ctl);

    a_r3_swallow_count: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && M_W'(a_act) < m_act) |->
        (hi_tot == (M_W+1)'(a_act) || hi_tot == (M_W+1)'(a_act) + 1'b1));

    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(p32_act) && $stable(cfg_err) && $stable(m_act) && $stable(a_act)));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mod_ctl && !div_pulse));

    a_r8_full_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && m_act != '0 && M_W'(a_act) >= m_act) |-> (hi_tot == {1'b0, m_act}));
endmodule

bind pswallow_frac_div pswallow_frac_div_chk #(.M_W(M_W), .A_W(A_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .state     (st_w),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse),
    .m_act     (m_act_w),
    .a_act     (a_act_w),
    .p32_act   (p32_act),
    .cfg_err   (cfg_err)
);

// File: tb/pswallow_frac_div_bench.sv
`timescale 1ns/1ps
module pswallow_frac_div_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] m_val = '0;
    logic [4:0]  a_val = '0;
    logic [4:0]  f_val = '0;
    logic        p32_sel = 1'b0;
    logic        mod_ctl, div_pulse, p32_act, cfg_err;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    pswallow_frac_div u_pswallow_frac_div (
        .clk(clk), .rst_n(rst_n), .m_val(m_val), .a_val(a_val), .f_val(f_val),
        .p32_sel(p32_sel), .mod_ctl(mod_ctl), .div_pulse(div_pulse),
        .p32_act(p32_act), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [10:0] m;
        logic [4:0]  a;
        logic [4:0]  f;
        logic        p32;
        logic [31:0] vco;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{11'd40, 5'd5,  5'd0,  1'b1, 32'd41120},
        '{11'd32, 5'd0,  5'd1,  1'b1, 32'd32769},
        '{11'd50, 5'd31, 5'd31, 1'b1, 32'd52223},
        '{11'd20, 5'd7,  5'd12, 1'b0, 32'd10476},
        '{11'd16, 5'd0,  5'd16, 1'b0, 32'd8208},
        '{11'd20, 5'd20, 5'd16, 1'b0, 32'd10880},
        '{11'd40, 5'd3,  5'd8,  1'b1, 32'd41064}
    };

    task automatic check(input string req, input bit ok, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
    endtask

    // measures one cycle from the next sampled period; len, highs, order flag
    task automatic measure_one(output int len, output int hi, output bit order_bad);
        bit seen_low = 0;
        len = 0; hi = 0; order_bad = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            len++;
            if (mod_ctl) begin
                hi++;
                if (seen_low) order_bad = 1;
            end else seen_low = 1;
            if (div_pulse) return;
        end
        check("watchdog", 0, len, -1);
    endtask

    initial begin
        int len, hi, len2, hi2;
        bit ob;
        int vco, per, carries, ordfail, len8car;
        int p;

        // R7: reset state
        m_val = 11'd40; a_val = 5'd5; f_val = 5'd3; p32_sel = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 reset mod_ctl", mod_ctl == 0, mod_ctl, 0);
        check("R7 reset div_pulse", div_pulse == 0, div_pulse, 0);
        check("R7 reset cfg_err", cfg_err == 0, cfg_err, 0);
        check("R7 reset p32_act", p32_act == 0, p32_act, 0);

        // Table walk: R1, R2, R3, R5, R6, R8
        for (int v = 0; v < NV; v++) begin
            m_val = VECS[v].m; a_val = VECS[v].a; f_val = VECS[v].f; p32_sel = VECS[v].p32;
            p = VECS[v].p32 ? 32 : 16;
            do_reset();
            vco = 0; per = 0; carries = 0; ordfail = 0; len8car = 0;
            for (int c = 0; c < 32; c++) begin
                measure_one(len, hi, ob);
                per += len;
                vco += hi * (p + 1) + (len - hi) * p;
                if (hi == int'(VECS[v].a) + 1) carries++;
                if (ob) ordfail++;
                if (c == 7) len8car = carries;
                if (len != int'(VECS[v].m)) check("R1 cycle length", 0, len, VECS[v].m);
            end
            check("R3 total input count", vco == int'(VECS[v].vco), vco, VECS[v].vco);
            check("R1 prescaler periods", per == 32 * int'(VECS[v].m), per, 32 * VECS[v].m);
            check("R2 swallow run contiguous", ordfail == 0, ordfail, 0);
            check("R5 p32_act", p32_act == VECS[v].p32, p32_act, VECS[v].p32);
            check("R6 cfg_err clear", cfg_err == 0, cfg_err, 0);
            if (VECS[v].a == VECS[v].m)
                check("R8 carries lost when A equals M", carries == 0, carries, 0);
            else
                check("R3 carry count", carries == int'(VECS[v].f), carries, VECS[v].f);
            if (VECS[v].f == 5'd12)
                check("R3 F=12 gives 3 carries in 8 cycles", len8car == 3, len8car, 3);
        end

        // R6: invalid configurations
        m_val = 11'd31; a_val = 5'd31; f_val = 5'd0; p32_sel = 1'b1;
        do_reset(); @(negedge clk);
        check("R6 ratio 1023 below 1024", cfg_err == 1, cfg_err, 1);
        m_val = 11'd20; a_val = 5'd21; p32_sel = 1'b0;
        do_reset(); @(negedge clk);
        check("R6 A above M", cfg_err == 1, cfg_err, 1);
        m_val = 11'd15; a_val = 5'd11; p32_sel = 1'b0;
        do_reset(); @(negedge clk);
        check("R6 ratio 251 below 256", cfg_err == 1, cfg_err, 1);

        // R4: mid-cycle change takes effect only at next boundary
        m_val = 11'd40; a_val = 5'd5; f_val = 5'd0; p32_sel = 1'b1;
        do_reset();
        repeat (10) @(negedge clk);
        m_val = 11'd60; a_val = 5'd2; p32_sel = 1'b0;
        @(negedge clk);
        check("R4 p32_act held mid-cycle", p32_act == 1, p32_act, 1);
        measure_one(len, hi, ob);
        check("R4 current cycle length kept", 11 + len == 40, 11 + len, 40);
        measure_one(len2, hi2, ob);
        check("R4 new length at boundary", len2 == 60, len2, 60);
        check("R4 new swallow count at boundary", hi2 == 2, hi2, 2);
        check("R5 p32_act updated at boundary", p32_act == 0, p32_act, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule